// File: doc/BRIEF.md
# Shared DRAM Address Multiplexer

This block places addresses onto a multiplexed DRAM address bus for memory that a CPU and a video fetch engine share. Each access begins with a one-cycle start pulse. On that pulse the block captures either the CPU address or the video address, along with the bank to use. It then runs a fixed strobe sequence. First it presents the row half of the address and pulls the common RAS low. Then it switches the bus to the column half and pulls low the CAS line of the chosen bank only. At the end it releases both strobes.

The address bits are split between row and column so that a plain linear video scan also refreshes the DRAM. Bits 8 to 1 form the row, so any 512 consecutive video addresses visit all 256 rows. Bit 0 sits in the column half, so the two back-to-back fetches of one character stay in the same open row. The two top address bits reach the bus only during the column phase of a CPU access. Video fetches drive those two column lines low.

Top module: `dram_addr_mux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 0, `ras_n` is 1, every `cas_n` bit is 1 and `ma` is 0.
- R2: A start pulse seen while idle raises `busy` in the next cycle. `busy` stays high for exactly 3 + CAS_CYC cycles and then drops.
- R3: A start pulse seen while `busy` is high is ignored. The running access keeps its captured address, source and bank, and it does not become longer.
- R4: The source is captured with the start pulse. `cpu_sel_n` = 0 selects `cpu_addr` and `cpu_sel_n` = 1 selects `vid_addr`. Input changes after the start pulse have no effect on the running access.
- R5: In the first and second cycles of an access, `ma[i]` equals captured address bit i+1 for i = 0..7. `ras_n` falls at the start of the second cycle.
- R6: From the third cycle through the end of the access, `ma[0]` equals address bit 0 and `ma[5:1]` equals address bits 13..9. `ma[7:6]` equals address bits 15..14 for a CPU access and is 00 for a video access.
- R7: `ma` holds the same value during the cycle before `ras_n` falls as in the cycle where it falls. The same holds for the cycle before any `cas_n` bit falls.
- R8: `ras_n` is low from the second cycle through the last CAS cycle. The captured bank's `cas_n` bit is low only in the final CAS_CYC cycles. At most one `cas_n` bit is ever low. No `cas_n` bit is low while `ras_n` is high, and both strobes are high whenever `busy` is low.
- R9: `bank_sel` is captured with the start pulse and held until CAS is released. `cas_n` bit b is driven by bank b.
- R10: Two addresses that differ only in bit 0 produce the same row value and column values that differ only in `ma[0]`.
- R11: Back-to-back video accesses to 512 consecutive addresses present all 256 row values within 250000 cycles, which is 2 ms at 125 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an access when idle |
| cpu_sel_n | input | 1 | Source select: 0 selects the CPU, 1 selects video |
| cpu_addr | input | 16 | CPU address |
| vid_addr | input | 16 | Video fetch address |
| bank_sel | input | BW | Bank whose CAS line is used |
| busy | output | 1 | High from the cycle after start until the strobes are released |
| ma | output | 8 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, shared by all banks |
| cas_n | output | NBANK | Column strobes, one per bank |

## Verification
The hardest case to provoke is a new start pulse that arrives during an access while the address, source and bank inputs are all changing. The bench does this on every access: one cycle after each accepted start it drives a second start with inverted address, source and bank. It then checks that the column half, the active CAS line and the access length all still match the first capture. The refresh property needs a long, unbroken linear video sweep. The bench issues 512 back-to-back video accesses, records the row present on the bus at each RAS fall, and compares the number of rows covered and the cycles used against the 2 ms budget.

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int NBANK   = 2,
  parameter int CAS_CYC = 2,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CW = $clog2(CAS_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cpu_sel_n,
  input  logic [15:0]      cpu_addr,
  input  logic [15:0]      vid_addr,
  input  logic [BW-1:0]    bank_sel,
  output logic             busy,
  output logic [7:0]       ma,
  output logic             ras_n,
  output logic [NBANK-1:0] cas_n
);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_RAS, S_COL, S_CAS} state_t;

  state_t          state;
  logic [15:0]     addr_q;
  logic            vid_q;
  logic [BW-1:0]   bank_q;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      vid_q  <= 1'b0;
      bank_q <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_q <= cpu_sel_n ? vid_addr : cpu_addr;
          vid_q  <= cpu_sel_n;
          bank_q <= bank_sel;
          state  <= S_ROW;
        end
        S_ROW: state <= S_RAS;
        S_RAS: state <= S_COL;
        S_COL: begin
          cnt   <= '0;
          state <= S_CAS;
        end
        S_CAS: begin
          if (cnt == CW'(CAS_CYC - 1)) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic       row_phase;
  logic [7:0] row_addr;
  logic [7:0] col_addr;

  assign row_phase = (state == S_ROW) || (state == S_RAS);
  assign row_addr  = addr_q[8:1];
  assign col_addr  = {vid_q ? 2'b00 : addr_q[15:14], addr_q[13:9], addr_q[0]};

  assign busy  = (state != S_IDLE);
  assign ma    = !busy ? 8'h00 : (row_phase ? row_addr : col_addr);
  assign ras_n = !((state == S_RAS) || (state == S_COL) || (state == S_CAS));

  for (genvar b = 0; b < NBANK; b++) begin : g_cas
    assign cas_n[b] = !((state == S_CAS) && (bank_q == BW'(b)));
  end

endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
  parameter int NBANK = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [7:0]       ma,
  input logic             ras_n,
  input logic [NBANK-1:0] cas_n
);

  p_one_cas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cas_n));

  p_cas_under_ras_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != {NBANK{1'b1}}) |-> !ras_n);

  p_idle_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && (cas_n == {NBANK{1'b1}})));

  p_ras_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy);

  p_ma_before_ras_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(ma));

  p_ma_before_cas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cas_n != {NBANK{1'b1}}) && ($past(cas_n) == {NBANK{1'b1}})) |-> $stable(ma));

endmodule

bind dram_addr_mux dram_addr_mux_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ma(ma), .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/sim_dram_addr_mux.sv
`timescale 1ns/1ps
module sim_dram_addr_mux;
  localparam int NBANK   = 2;
  localparam int CAS_CYC = 2;
  localparam int BW      = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cpu_sel_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] vid_addr = '0;
  logic [BW-1:0] bank_sel = '0;
  logic busy;
  logic [7:0] ma;
  logic ras_n;
  logic [NBANK-1:0] cas_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_addr_mux #(.NBANK(NBANK), .CAS_CYC(CAS_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cpu_sel_n(cpu_sel_n),
    .cpu_addr(cpu_addr), .vid_addr(vid_addr), .bank_sel(bank_sel),
    .busy(busy), .ma(ma), .ras_n(ras_n), .cas_n(cas_n)
  );

  function automatic logic [7:0] exp_row(input logic [15:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = a[i+1];
    return r;
  endfunction

  function automatic logic [7:0] exp_col(input logic [15:0] a, input logic vid);
    return {vid ? 2'b00 : a[15:14], a[13:9], a[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic vid, input logic [BW-1:0] bk,
                        output logic [7:0] row_seen, output logic [7:0] col_seen);
    logic [NBANK-1:0] cas_exp;
    cas_exp = ~(NBANK'(1) << bk);
    @(negedge clk);
    start = 1'b1; cpu_sel_n = vid; bank_sel = bk;
    cpu_addr = vid ? ~a : a;
    vid_addr = vid ? a : ~a;
    @(negedge clk);
    chk("R2 busy rises", {31'd0, busy}, 32'd1);
    chk("R5 row cycle1 ma", {24'd0, ma}, {24'd0, exp_row(a)});
    chk("R5 ras high cycle1", {31'd0, ras_n}, 32'd1);
    // R3/R4: a second request with altered inputs while busy
    start = 1'b1; cpu_sel_n = ~vid; bank_sel = ~bk;
    cpu_addr = ~cpu_addr; vid_addr = ~vid_addr;
    @(negedge clk);
    start = 1'b0;
    row_seen = ma;
    chk("R5 ras low cycle2", {31'd0, ras_n}, 32'd0);
    chk("R5 row cycle2 ma", {24'd0, ma}, {24'd0, exp_row(a)});
    chk("R8 no cas cycle2", {30'd0, cas_n}, {30'd0, {NBANK{1'b1}}});
    @(negedge clk);
    chk("R6 col ma", {24'd0, ma}, {24'd0, exp_col(a, vid)});
    chk("R8 ras low col", {31'd0, ras_n}, 32'd0);
    chk("R8 no cas col", {30'd0, cas_n}, {30'd0, {NBANK{1'b1}}});
    for (int k = 0; k < CAS_CYC; k++) begin
      @(negedge clk);
      col_seen = ma;
      chk("R9 R3 cas bank", {30'd0, cas_n}, {30'd0, cas_exp});
      chk("R6 R4 col hold", {24'd0, ma}, {24'd0, exp_col(a, vid)});
      chk("R8 ras low cas", {31'd0, ras_n}, 32'd0);
    end
    @(negedge clk);
    chk("R2 R3 busy drops", {31'd0, busy}, 32'd0);
    chk("R8 release", {29'd0, ras_n, cas_n}, {29'd0, 1'b1, {NBANK{1'b1}}});
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r0, c0, r1, c1;
    logic [255:0] seen;
    logic [15:0] base;
    int t0, n;
    void'($urandom(32'd20240406));

    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset strobes", {29'd0, ras_n, cas_n}, {29'd0, 1'b1, {NBANK{1'b1}}});
    chk("R1 reset ma", {24'd0, ma}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {20'd0, busy, ras_n, cas_n, ma}, {20'd0, 1'b0, 1'b1, {NBANK{1'b1}}, 8'h00});

    // R6: top bits only reach the bus for the CPU source
    access(16'hC3A5, 1'b0, 1'b0, r0, c0);
    chk("R6 cpu top bits", {30'd0, c0[7:6]}, 32'd3);
    access(16'hC3A5, 1'b1, 1'b1, r1, c1);
    chk("R6 video top bits zero", {30'd0, c1[7:6]}, 32'd0);
    chk("R4 same row both sources", {24'd0, r1}, {24'd0, r0});

    // R10: A0 lives in the column half
    access(16'h5A5A, 1'b1, 1'b0, r0, c0);
    access(16'h5A5B, 1'b1, 1'b0, r1, c1);
    chk("R10 same row", {24'd0, r1}, {24'd0, r0});
    chk("R10 col differs in bit0", {24'd0, c0 ^ c1}, 32'd1);

    access(16'hFFFF, 1'b0, 1'b1, r0, c0);
    access(16'h0000, 1'b1, 1'b0, r0, c0);

    for (int i = 0; i < 40; i++)
      access(16'($urandom), 1'($urandom), BW'($urandom), r0, c0);

    // R11: linear video sweep refreshes every row
    seen = '0;
    base = 16'($urandom);
    t0 = cyc;
    for (int i = 0; i < 512; i++) begin
      access(base + 16'(i), 1'b1, BW'(i), r0, c0);
      seen[r0] = 1'b1;
    end
    n = 0;
    for (int i = 0; i < 256; i++) if (seen[i]) n++;
    chk("R11 rows covered", n, 256);
    chk("R11 within 2ms", {31'd0, (cyc - t0) <= 250000}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule